// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

The block is a watchdog counter that runs from the system clock and cannot be switched off. Once reset is released it counts down from a configured timeout. Software must strobe an acknowledge input often enough that the count never reaches zero. Each acknowledge reloads the counter and puts the block back into its first stage.

If the count reaches zero without an acknowledge, the block raises a sticky interrupt, reloads the counter and enters a warned stage. The interrupt lets software recover without a reset. If the count reaches zero again before any acknowledge arrives, the block issues a system reset request for one clock cycle. It then returns to its post-reset condition with a freshly loaded counter. Distributing that reset and decoding the bus registers that feed the timeout value are handled outside this block.

The timeout value is sampled only when the counter reloads. A counter loaded with T therefore expires T+1 clock edges after the edge that loaded it.

Top module: `wdog_escalator`

## Requirements
- R1: While `rstN` is low (sampled on the clock edge), the counter loads `timeoutCfg`, `irqOut` is 0 and `resetReq` is 0. With no acknowledge after release, `irqOut` rises T+1 edges after the last reset edge.
- R2: When there is no acknowledge and no reload, the counter decrements by one on every clock edge until it reaches zero. No input pauses or disables it.
- R3: `irqClear` has no effect on the counter or the stage: pulsing it does not shift the time at which `irqOut` or `resetReq` next asserts.
- R4: In the first stage, an expiry (count at zero with no acknowledge) sets `irqOut`, reloads the counter and enters the warned stage.
- R5: In the warned stage, an expiry drives `resetReq` high for exactly one cycle, T+1 edges after the edge on which `irqOut` rose.
- R6: The edge after the reset pulse clears `irqOut`, returns the block to the first stage and reloads the counter. The next `irqOut` then rises T+2 edges after the edge that raised `resetReq`.
- R7: An acknowledge (`ackStrobe` high on an edge) in any stage reloads the counter, returns the block to the first stage and clears `irqOut`. It takes priority over an expiry on the same edge.
- R8: `irqOut` stays high until an `irqClear`, an acknowledge or the end of a reset pulse. If a set and an `irqClear` fall on the same edge, the set wins.
- R9: A change of `timeoutCfg` does not alter a count in progress. The new value is used from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| timeoutCfg | input | CNT_W | Timeout value T, sampled on each reload |
| ackStrobe | input | 1 | Software acknowledge, one cycle per acknowledge |
| irqClear | input | 1 | Clears the interrupt flag |
| irqOut | output | 1 | Sticky first-stage interrupt |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The bench measures edge counts directly, from an acknowledge or reset release to the interrupt and from the interrupt to the reset pulse. A design with an off-by-one load or decrement would miss those counts by one. It clears the interrupt in the warned stage and then checks that the reset request still arrives on time: a design that let the clear rewind the stage would never reset. It also changes the timeout in the middle of a count, where a design that reads the value live would fire early, and it acknowledges during the warned stage, where a design that only reloaded the counter would still escalate. Random acknowledges, clears, timeout changes and resets are compared cycle by cycle against a bench reference model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_RUN         = 2'd0,
    ST_WARNED      = 2'd1,
    ST_RESET_PULSE = 2'd2
  } wdState_e;

  typedef struct packed {
    logic reload;
    logic decEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wdog_pkg::ctrlStrobes_t   strobes,
  input  logic [CNT_W-1:0]         timeoutCfg,
  output logic [CNT_W-1:0]         count,
  output logic                     expired
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= timeoutCfg;
    end else if (strobes.reload) begin
      count <= timeoutCfg;
    end else if (strobes.decEn && (count != ZERO)) begin
      count <= count - ONE;
    end
  end

  assign expired = (count == ZERO);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    expired,
  input  logic                    ackStrobe,
  input  logic                    irqClear,
  output wdog_pkg::ctrlStrobes_t  strobes,
  output wdog_pkg::wdState_e      ctrlState,
  output logic                    irqOut,
  output logic                    resetReq
);
  import wdog_pkg::*;

  wdState_e stateNext;
  logic     setIrq;
  logic     dropIrq;

  always_comb begin
    stateNext      = ctrlState;
    strobes.reload = 1'b0;
    strobes.decEn  = 1'b1;
    setIrq         = 1'b0;
    dropIrq        = 1'b0;
    if (ackStrobe) begin
      stateNext      = ST_RUN;
      strobes.reload = 1'b1;
      dropIrq        = 1'b1;
    end else begin
      unique case (ctrlState)
        ST_RUN: begin
          if (expired) begin
            stateNext      = ST_WARNED;
            strobes.reload = 1'b1;
            setIrq         = 1'b1;
          end
        end
        ST_WARNED: begin
          if (expired) begin
            stateNext      = ST_RESET_PULSE;
            strobes.reload = 1'b1;
          end
        end
        ST_RESET_PULSE: begin
          stateNext      = ST_RUN;
          strobes.reload = 1'b1;
          dropIrq        = 1'b1;
        end
        default: begin
          stateNext      = ST_RUN;
          strobes.reload = 1'b1;
          dropIrq        = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlState <= ST_RUN;
      irqOut    <= 1'b0;
    end else begin
      ctrlState <= stateNext;
      if (dropIrq)       irqOut <= 1'b0;
      else if (setIrq)   irqOut <= 1'b1;
      else if (irqClear) irqOut <= 1'b0;
    end
  end

  assign resetReq = (ctrlState == ST_RESET_PULSE);
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] timeoutCfg,
  input  logic             ackStrobe,
  input  logic             irqClear,
  output logic             irqOut,
  output logic             resetReq
);
  import wdog_pkg::*;

  ctrlStrobes_t     strobes;
  wdState_e         ctrlState;
  logic [CNT_W-1:0] count;
  logic             expired;

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .timeoutCfg (timeoutCfg),
    .count      (count),
    .expired    (expired)
  );

  wdog_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .expired   (expired),
    .ackStrobe (ackStrobe),
    .irqClear  (irqClear),
    .strobes   (strobes),
    .ctrlState (ctrlState),
    .irqOut    (irqOut),
    .resetReq  (resetReq)
  );
endmodule

// File: rtl/wdog_escalator_chk.sv
module wdog_escalator_chk #(
  parameter int CNT_W = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic [CNT_W-1:0]    timeoutCfg,
  input logic                ackStrobe,
  input logic                irqClear,
  input logic                irqOut,
  input logic                resetReq,
  input wdog_pkg::wdState_e  ctrlState,
  input logic [CNT_W-1:0]    count
);
  import wdog_pkg::*;

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ackStrobe && count != '0 && ctrlState != ST_RESET_PULSE) |=> count == ($past(count) - 1'b1));

  p_irq_on_expiry_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(count) == '0 && $past(ctrlState) == ST_RUN));

  p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  p_after_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (!irqOut && ctrlState == ST_RUN));

  p_ack_rewinds_r7: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> (!irqOut && !resetReq && ctrlState == ST_RUN));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqClear && !ackStrobe && !resetReq) |=> irqOut);

  p_reload_value_r9: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> count == $past(timeoutCfg));
endmodule

bind wdog_escalator wdog_escalator_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .timeoutCfg (timeoutCfg),
  .ackStrobe  (ackStrobe),
  .irqClear   (irqClear),
  .irqOut     (irqOut),
  .resetReq   (resetReq),
  .ctrlState  (ctrlState),
  .count      (count)
);

// File: tb/wdog_escalator_bench.sv
`timescale 1ns/1ps
module wdog_escalator_bench;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] timeoutCfg = 12'd5;
  logic             ackStrobe = 1'b0;
  logic             irqClear = 1'b0;
  logic             irqOut;
  logic             resetReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_escalator #(.CNT_W(CNT_W)) u_wdog_escalator (
    .clk(clk), .rstN(rstN), .timeoutCfg(timeoutCfg), .ackStrobe(ackStrobe),
    .irqClear(irqClear), .irqOut(irqOut), .resetReq(resetReq)
  );

  // Reference model: stage 0 = first, 1 = warned, 2 = reset pulse
  int mCnt, mSt;
  bit mIrq;

  function automatic int expPeriod(input int t);
    return t + 1;
  endfunction

  always @(posedge clk) begin
    int  nCnt, nSt;
    bit  nIrq, rel;
    if (!rstN) begin
      mCnt <= int'(timeoutCfg); mSt <= 0; mIrq <= 1'b0;
    end else begin
      nSt = mSt; nIrq = mIrq; rel = 1'b0;
      if (ackStrobe) begin
        nSt = 0; rel = 1'b1; nIrq = 1'b0;
      end else if (mSt == 0) begin
        if (mCnt == 0) begin nSt = 1; rel = 1'b1; nIrq = 1'b1; end
        else if (irqClear) nIrq = 1'b0;
      end else if (mSt == 1) begin
        if (mCnt == 0) begin nSt = 2; rel = 1'b1; end
        if (irqClear) nIrq = 1'b0;
      end else begin
        nSt = 0; rel = 1'b1; nIrq = 1'b0;
      end
      nCnt = rel ? int'(timeoutCfg) : ((mCnt != 0) ? mCnt - 1 : 0);
      mCnt <= nCnt; mSt <= nSt; mIrq <= nIrq;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(irqOut == mIrq, "R4/R7/R8 irqOut vs model", int'(irqOut), int'(mIrq));
      check(resetReq == (mSt == 2), "R5/R6 resetReq vs model", int'(resetReq), int'(mSt == 2));
    end
  end

  task automatic countUntilIrq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irqOut && n < 5000);
  endtask

  task automatic countUntilRst(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!resetReq && n < 5000);
  endtask

  task automatic pulseAck();
    ackStrobe = 1'b1; @(negedge clk); ackStrobe = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(irqOut == 1'b0, "R1 irqOut in reset", int'(irqOut), 0);
    check(resetReq == 1'b0, "R1 resetReq in reset", int'(resetReq), 0);
    rstN = 1'b1;
    countUntilIrq(n);
    check(n == expPeriod(5), "R1/R2/R4 edges from reset release to irq", n, expPeriod(5));
    countUntilRst(n);
    check(n == expPeriod(5), "R5 edges from irq to resetReq", n, expPeriod(5));
    @(negedge clk);
    check(resetReq == 1'b0, "R5 resetReq width one cycle", int'(resetReq), 0);
    check(irqOut == 1'b0, "R6 irq cleared after reset pulse", int'(irqOut), 0);
    n = 1;
    while (!irqOut && n < 5000) begin @(negedge clk); n++; end
    check(n == 5 + 2, "R6 edges from resetReq to next irq", n, 7);

    // R7: acknowledge in warned stage rewinds
    pulseAck();
    check(irqOut == 1'b0, "R7 ack clears irq", int'(irqOut), 0);
    countUntilIrq(n);
    check(n == expPeriod(5), "R7 ack reloads full period", n, expPeriod(5));

    // R3/R8: clear in warned stage keeps escalation timing
    @(negedge clk);
    irqClear = 1'b1; @(negedge clk); irqClear = 1'b0;
    check(irqOut == 1'b0, "R8 irqClear drops irq", int'(irqOut), 0);
    countUntilRst(n);
    check(n == expPeriod(5) - 2, "R3 irqClear leaves stage and count", n, expPeriod(5) - 2);
    @(negedge clk);

    // R9: mid-count change of the timeout
    timeoutCfg = 12'd8;
    pulseAck();
    @(negedge clk); @(negedge clk);
    timeoutCfg = 12'd3;
    n = 2;
    while (!irqOut && n < 5000) begin @(negedge clk); n++; end
    check(n == expPeriod(8), "R9 running count keeps old timeout", n, expPeriod(8));
    countUntilRst(n);
    check(n == expPeriod(3), "R9 new timeout used at next reload", n, expPeriod(3));
    @(negedge clk);

    // R8: set wins over a simultaneous clear, timeout of zero
    timeoutCfg = 12'd0;
    pulseAck();
    irqClear = 1'b1; @(negedge clk); irqClear = 1'b0;
    check(irqOut == 1'b1, "R8 set wins over clear", int'(irqOut), 1);

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(63) == 0) timeoutCfg = CNT_W'($urandom_range(15));
      ackStrobe = ($urandom_range(29) == 0);
      irqClear  = ($urandom_range(11) == 0);
      rstN      = !($urandom_range(499) == 0);
      @(negedge clk);
    end
    ackStrobe = 1'b0; irqClear = 1'b0; rstN = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule